// File: doc/BRIEF.md
# Single-Clock FIFO with Loadable Almost-Flag Thresholds

This block is a first-in first-out buffer for nine-bit words. The number of words it holds is a parameter. The write port and the read port share one clock. Words written while the buffer has room come out of the read port in the order they went in. Four active-low status outputs report the occupancy: empty, full, almost-empty and almost-full.

The almost-empty and almost-full flags compare the occupancy against two 18-bit threshold registers. Neither register is a parameter. Software sets them through the ordinary data ports. While the load control `ld_n` is held LOW, the data ports stop serving the buffer. Each enabled write edge then stores the nine-bit input into the next half of the thresholds. Each enabled read edge shows the next half of the thresholds on the output. Both walks use the same fixed four-step order, and a clock edge with `ld_n` HIGH starts either walk over from the first step.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset, `empty_n` and `almost_empty_n` are 0, `full_n` and `almost_full_n` are 1, both thresholds are zero, and `rd_data` is 0.
- R2: With `ld_n` HIGH, each edge with `wr_en` and room stores `wr_data`. Each edge with `rd_en` and at least one word held loads the oldest word onto `rd_data`, where it is visible after that edge. Words leave in the order they were written.
- R3: A write at an edge where the buffer already holds DEPTH words is dropped. The contents, the occupancy and the flags do not change. A simultaneous read is still performed.
- R4: A read at an edge where the buffer is empty is dropped. `rd_data` holds its value. A simultaneous write is still performed.
- R5: `empty_n` is 0 exactly when the occupancy is 0, and `full_n` is 0 exactly when the occupancy is DEPTH. Both follow the edge that changes the occupancy. A read and a write accepted at the same edge leave the occupancy unchanged.
- R6: `almost_empty_n` is 0 exactly when the occupancy is at most the empty threshold n.
- R7: `almost_full_n` is 0 exactly when occupancy + m is at least DEPTH, where m is the full threshold. It is 1 once more than m locations are free.
- R8: While `ld_n` is LOW, each edge with `wr_en` stores `wr_data` into the next threshold half. Step 0 is n bits 8:0, step 1 is n bits 17:9, step 2 is m bits 8:0 and step 3 is m bits 17:9. After step 3 the walk wraps to step 0. These edges do not change the buffer.
- R9: While `ld_n` is LOW, each edge with `rd_en` places the next threshold half on `rd_data`, in the order of R8, using a step counter separate from the load counter. These edges do not remove a word.
- R10: A clock edge with `ld_n` HIGH returns both step counters to step 0. An edge with `ld_n` LOW and the enable idle keeps that counter's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common write and read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | LOW routes the data ports to the threshold registers |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 9 | Write data or threshold half |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 9 | Read data or threshold half |
| empty_n | output | 1 | LOW when no word is held |
| full_n | output | 1 | LOW when DEPTH words are held |
| almost_empty_n | output | 1 | LOW when occupancy is at most n |
| almost_full_n | output | 1 | LOW when occupancy + m reaches DEPTH |

## Verification
The hardest state to reach from the ports combines an off-step threshold walk with a buffer that sits at full or empty. That happens when a load or readback sequence is broken by an `ld_n` HIGH edge, or is mixed into traffic, while the occupancy is at a boundary. The random phases bias the enables so that the buffer fills and drains to both ends many times. Short readback bursts with `ld_n` LOW are scattered through that traffic. Directed sequences break the load walk with idle edges, wrap it past step 3, and set high-half thresholds large enough that an almost-flag stays asserted at every occupancy.

// File: rtl/pff_pkg.sv
package pff_pkg;

    // Position in the four-step threshold walk (order is behaviour)
    typedef enum logic [1:0] {
        STEP_EMPTY_LO = 2'd0,
        STEP_EMPTY_HI = 2'd1,
        STEP_FULL_LO  = 2'd2,
        STEP_FULL_HI  = 2'd3
    } thr_step_e;

    function automatic thr_step_e next_step(thr_step_e s);
        return thr_step_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/pff_storage.sv
module pff_storage #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pff_thr_regs.sv
module pff_thr_regs
    import pff_pkg::*;
#(
    parameter int DATA_W = 9,
    localparam int THR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [THR_W-1:0]  empty_thr,
    output logic [THR_W-1:0]  full_thr,
    output logic [DATA_W-1:0] rb_data
);

    typedef struct packed {
        logic [THR_W-1:0]  empty_thr;
        logic [THR_W-1:0]  full_thr;
        thr_step_e         load_step;
        thr_step_e         show_step;
        logic [DATA_W-1:0] rb;
    } thr_state_t;

    thr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_n) begin
            st_d.load_step = STEP_EMPTY_LO;
            st_d.show_step = STEP_EMPTY_LO;
        end else begin
            if (rd_en) begin
                unique case (st_q.show_step)
                    STEP_EMPTY_LO: st_d.rb = st_q.empty_thr[DATA_W-1:0];
                    STEP_EMPTY_HI: st_d.rb = st_q.empty_thr[THR_W-1:DATA_W];
                    STEP_FULL_LO:  st_d.rb = st_q.full_thr[DATA_W-1:0];
                    STEP_FULL_HI:  st_d.rb = st_q.full_thr[THR_W-1:DATA_W];
                    default:       st_d.rb = st_q.rb;
                endcase
                st_d.show_step = next_step(st_q.show_step);
            end
            if (wr_en) begin
                unique case (st_q.load_step)
                    STEP_EMPTY_LO: st_d.empty_thr[DATA_W-1:0]     = wr_data;
                    STEP_EMPTY_HI: st_d.empty_thr[THR_W-1:DATA_W] = wr_data;
                    STEP_FULL_LO:  st_d.full_thr[DATA_W-1:0]      = wr_data;
                    STEP_FULL_HI:  st_d.full_thr[THR_W-1:DATA_W]  = wr_data;
                    default:       st_d.full_thr                  = st_q.full_thr;
                endcase
                st_d.load_step = next_step(st_q.load_step);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{empty_thr: '0, full_thr: '0, load_step: STEP_EMPTY_LO,
                      show_step: STEP_EMPTY_LO, rb: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_thr = st_q.empty_thr;
    assign full_thr  = st_q.full_thr;
    assign rb_data   = st_q.rb;

endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl #(
    parameter int DEPTH  = 64,
    parameter int THR_W  = 18,
    parameter int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CMP_W = ((THR_W > CNT_W) ? THR_W : CNT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [THR_W-1:0]  empty_thr,
    input  logic [THR_W-1:0]  full_thr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] waddr,
    output logic              mem_re,
    output logic [ADDR_W-1:0] raddr,
    output logic              empty_n,
    output logic              full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [ADDR_W-1:0] PTR_LAST = ADDR_W'(DEPTH - 1);
    localparam logic [CMP_W-1:0]  DEPTH_C  = CMP_W'(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [CNT_W-1:0]  count;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        wr_ok, rd_ok;
    logic [CMP_W-1:0] cnt_ext, fill_sum;

    always_comb begin
        wr_ok = ld_n && wr_en && (st_q.count != CNT_MAX);
        rd_ok = ld_n && rd_en && (st_q.count != '0);
        st_d  = st_q;
        if (wr_ok) begin
            st_d.wptr = (st_q.wptr == PTR_LAST) ? '0 : st_q.wptr + 1'b1;
        end
        if (rd_ok) begin
            st_d.rptr = (st_q.rptr == PTR_LAST) ? '0 : st_q.rptr + 1'b1;
        end
        unique case ({wr_ok, rd_ok})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cnt_ext        = CMP_W'(st_q.count);
        fill_sum       = cnt_ext + CMP_W'(full_thr);
        empty_n        = (st_q.count != '0);
        full_n         = (st_q.count != CNT_MAX);
        almost_empty_n = !(cnt_ext <= CMP_W'(empty_thr));
        almost_full_n  = !(fill_sum >= DEPTH_C);
    end

    assign mem_we = wr_ok;
    assign mem_re = rd_ok;
    assign waddr  = st_q.wptr;
    assign raddr  = st_q.rptr;

endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int THR_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);

    logic [THR_W-1:0]  empty_thr, full_thr;
    logic [DATA_W-1:0] rb_data, mem_data;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              show_thr_d, show_thr_q;

    pff_thr_regs #(.DATA_W(DATA_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .empty_thr(empty_thr),
        .full_thr(full_thr), .rb_data(rb_data)
    );

    pff_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en(wr_en), .rd_en(rd_en),
        .empty_thr(empty_thr), .full_thr(full_thr), .mem_we(mem_we),
        .waddr(waddr), .mem_re(mem_re), .raddr(raddr), .empty_n(empty_n),
        .full_n(full_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n)
    );

    pff_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .re(mem_re), .raddr(raddr), .rdata(mem_data)
    );

    // Output source follows whichever read kind happened last
    always_comb begin
        show_thr_d = show_thr_q;
        if (!ld_n && rd_en) begin
            show_thr_d = 1'b1;
        end else if (mem_re) begin
            show_thr_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            show_thr_q <= 1'b0;
        end else begin
            show_thr_q <= show_thr_d;
        end
    end

    assign rd_data = show_thr_q ? rb_data : mem_data;

endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty_n,
    input logic              full_n,
    input logic              almost_empty_n,
    input logic              almost_full_n
);

    // R3: a lone write when full leaves the buffer full
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && wr_en && !rd_en && !full_n) |=> !full_n);

    // R4: a lone read when empty leaves data and empty flag alone
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && rd_en && !wr_en && !empty_n) |=> ($stable(rd_data) && !empty_n));

    // R5: empty and full never together
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    // R5: accepted read plus write keeps occupancy, so all flags hold
    a_r5_simul_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && wr_en && rd_en && empty_n && full_n) |=>
        ($stable(empty_n) && $stable(full_n) && $stable(almost_empty_n)
         && $stable(almost_full_n)));

    // R6: an empty buffer is always almost-empty
    a_r6_empty_implies_ae: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    // R9: threshold access edges never move the occupancy
    a_r9_load_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> ($stable(empty_n) && $stable(full_n)));

endmodule

bind prog_flag_fifo pff_checker #(.DATA_W(DATA_W)) u_pff_checker (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
);

// File: tb/prog_flag_fifo_test.sv
module prog_flag_fifo_test;

    localparam int DW = 9;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          empty_n, full_n, almost_empty_n, almost_full_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DW-1:0]   q[$];
    logic [2*DW-1:0] m_n = '0, m_m = '0;
    int              lstep = 0, sstep = 0;
    logic [DW-1:0]   exp_rd = '0;

    always #2.5 clk = ~clk;

    prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] half(int s);
        case (s)
            0: return m_n[DW-1:0];
            1: return m_n[2*DW-1:DW];
            2: return m_m[DW-1:0];
            default: return m_m[2*DW-1:DW];
        endcase
    endfunction

    function automatic bit exp_ae(int cnt);
        return !(longint'(cnt) <= longint'(m_n));
    endfunction

    function automatic bit exp_af(int cnt);
        return !(longint'(cnt) + longint'(m_m) >= longint'(DEPTH));
    endfunction

    task automatic check_outputs();
        chk("R5 empty_n", 32'(empty_n), 32'(q.size() != 0));
        chk("R5 full_n", 32'(full_n), 32'(q.size() != DEPTH));
        chk("R6 almost_empty_n", 32'(almost_empty_n), 32'(exp_ae(q.size())));
        chk("R7 almost_full_n", 32'(almost_full_n), 32'(exp_af(q.size())));
        chk("R2/R4/R9 rd_data", 32'(rd_data), 32'(exp_rd));
    endtask

    // One clock: drive after falling edge, model and sample after rising edge
    task automatic cyc(bit w, bit r, bit l, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; ld_n = l; wr_data = d;
        @(posedge clk);
        #1;
        if (!l) begin
            if (r) begin
                exp_rd = half(sstep);
                sstep = (sstep + 1) % 4;
            end
            if (w) begin
                case (lstep)
                    0: m_n[DW-1:0] = d;
                    1: m_n[2*DW-1:DW] = d;
                    2: m_m[DW-1:0] = d;
                    default: m_m[2*DW-1:DW] = d;
                endcase
                lstep = (lstep + 1) % 4;
            end
        end else begin
            bit wok, rok;
            lstep = 0; sstep = 0;
            wok = w && (q.size() < DEPTH);
            rok = r && (q.size() > 0);
            if (rok) exp_rd = q.pop_front();
            if (wok) q.push_back(d);
        end
        check_outputs();
    endtask

    task automatic load_thr(logic [17:0] n, logic [17:0] m);
        cyc(1, 0, 0, n[8:0]);
        cyc(1, 0, 0, n[17:9]);
        cyc(1, 0, 0, m[8:0]);
        cyc(1, 0, 0, m[17:9]);
        cyc(0, 0, 1, '0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk("R1 empty_n", 32'(empty_n), 0);
        chk("R1 almost_empty_n", 32'(almost_empty_n), 0);
        chk("R1 full_n", 32'(full_n), 1);
        chk("R1 almost_full_n", 32'(almost_full_n), 1);
        chk("R1 rd_data", 32'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: thresholds read back as zero
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0);
        cyc(0, 0, 1, '0);

        // R8/R9: load then read back each half in order
        load_thr({9'd0, 9'd3}, {9'd0, 9'd4});
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0);
        cyc(0, 0, 1, '0);

        // R10: broken walk restarts at step 0; idle load edge holds step
        cyc(1, 0, 0, 9'd7);
        cyc(0, 0, 0, '0);
        cyc(1, 0, 0, 9'd0);
        cyc(0, 0, 1, '0);
        cyc(1, 0, 0, 9'd2);
        cyc(0, 0, 1, '0);
        // R10: wrap after step 3 lands on step 0 again
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, (i == 4) ? 9'd5 : half(lstep));
        cyc(0, 1, 0, '0);
        chk("R10 wrap value", 32'(rd_data), 5);
        cyc(0, 0, 1, '0);

        // R3/R4: directed overflow and underflow
        cyc(0, 1, 1, '0);
        for (int i = 0; i < DEPTH + 3; i++) cyc(1, 0, 1, 9'(i + 32));
        cyc(1, 1, 1, 9'h1ff);
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1, 1, '0);
        cyc(1, 1, 1, 9'h0aa);
        cyc(0, 1, 1, '0);

        // R2/R5/R6/R7/R9: random traffic with scattered readback bursts
        for (int ph = 0; ph < 40; ph++) begin
            int wp = (ph % 2 == 0) ? 75 : 25;
            for (int i = 0; i < 60; i++) begin
                bit w = ($urandom % 100) < wp;
                bit r = ($urandom % 100) < (100 - wp);
                if (($urandom % 50) == 0) begin
                    cyc(0, 1, 0, '0);
                    cyc(0, 1, 0, '0);
                end else begin
                    cyc(w, r, 1, 9'($urandom));
                end
            end
            if (ph == 13) load_thr({9'd0, 9'd9}, {9'd0, 9'd1});
            if (ph == 27) load_thr({9'd0, 9'd0}, {9'd0, 9'd0});
        end

        // R6/R7: high halves force the almost-flags at every occupancy
        load_thr({9'd1, 9'd0}, {9'd1, 9'd0});
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, 9'(i));
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 1, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule